// File: doc/BRIEF.md
# Interrupt cause register unit

This block collects the interrupt events of one event group, such as a receive, transmit or miscellaneous group, into a sticky cause register. Each bit of the cause register is set by a one-cycle event pulse on its input line, or by software through a dedicated set register for test. The bit stays set until software acknowledges it. Each bit has its own acknowledge method, chosen at run time by a clear-mode register. A bit in write-one-to-clear mode is cleared by writing a one to it at the cause address. A bit in clear-on-read mode is cleared by reading the cause address.

Sources are disabled through a mask. The mask is never written directly. One write-only register sets mask bits and another clears them, so several agents can enable and disable their own sources without a read-modify-write race. The current mask can be read back through a read-only view. A second read-only view returns the cause bits of the enabled sources. The single level interrupt output is high while any enabled source has its cause bit set. All access goes through a simple synchronous register bus. Writes take effect on the clock edge. Read data is returned combinationally in the same cycle.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the mask is all ones, the cause register is all zeros, the clear-mode register is all zeros, and the interrupt output is low.
- R2: A write to address 1 (mask set) sets every mask bit written as one and leaves the mask bits written as zero unchanged.
- R3: A write to address 2 (mask clear) clears every mask bit written as one and leaves the mask bits written as zero unchanged.
- R4: An event pulse on bit i sets cause bit i at the next clock edge whatever the mask is. The bit then holds until it is cleared.
- R5: A write to address 4 (software set) sets the cause bits written as one at the next clock edge, in the same way as an event pulse.
- R6: A write to address 0 (cause) clears the cause bits written as one whose clear-mode bit is 0. Cause bits whose clear-mode bit is 1 are not changed by such a write.
- R7: A read of address 0 returns the cause value held before the read. At the next edge it clears every cause bit whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are not changed by the read. Address 3 reads and writes the clear-mode register.
- R8: An event on a bit in the same cycle as a clear of that bit, by either method, leaves the bit set.
- R9: The interrupt output is high exactly while some cause bit is 1 and its mask bit is 0.
- R10: A read of address 5 returns the mask. A read of address 6 returns the cause bits ANDed with the inverted mask, and clears nothing. Reads of addresses 1, 2, 4 and 7, and the read data outside a read cycle, are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | WIDTH | Event pulses, one per cause bit |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid in the read cycle |
| irq_o | output | 1 | Level interrupt of the group |

## Verification
The bench builds the unit with WIDTH = 32 and ADDR_W = 3. These are the full word width and the smallest address width that reaches every register plus one unused code. At this size one word can hold bits in both clear modes, which lets a single acknowledge write or read show that each bit obeys its own mode. The random phase drives all eight address codes with full 32-bit data and sparse event patterns. This brings event and clear collisions, and the unused address, within reach of the per-cycle comparison.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_CAUSE  = 0;
    localparam int ADDR_MSET   = 1;
    localparam int ADDR_MCLR   = 2;
    localparam int ADDR_MODE   = 3;
    localparam int ADDR_SOFT   = 4;
    localparam int ADDR_MVIEW  = 5;
    localparam int ADDR_ACTIVE = 6;

    typedef struct packed {
        logic wr_cause;
        logic wr_mset;
        logic wr_mclr;
        logic wr_mode;
        logic wr_soft;
        logic rd_cause;
        logic rd_mode;
        logic rd_mview;
        logic rd_active;
    } irqc_strobe_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output irqc_strobe_t      stb_o
);
    logic wr_en, rd_en;

    always_comb begin
        wr_en = bus_sel & bus_wr;
        rd_en = bus_sel & ~bus_wr;
        stb_o.wr_cause  = wr_en & (bus_addr == ADDR_W'(ADDR_CAUSE));
        stb_o.wr_mset   = wr_en & (bus_addr == ADDR_W'(ADDR_MSET));
        stb_o.wr_mclr   = wr_en & (bus_addr == ADDR_W'(ADDR_MCLR));
        stb_o.wr_mode   = wr_en & (bus_addr == ADDR_W'(ADDR_MODE));
        stb_o.wr_soft   = wr_en & (bus_addr == ADDR_W'(ADDR_SOFT));
        stb_o.rd_cause  = rd_en & (bus_addr == ADDR_W'(ADDR_CAUSE));
        stb_o.rd_mode   = rd_en & (bus_addr == ADDR_W'(ADDR_MODE));
        stb_o.rd_mview  = rd_en & (bus_addr == ADDR_W'(ADDR_MVIEW));
        stb_o.rd_active = rd_en & (bus_addr == ADDR_W'(ADDR_ACTIVE));
    end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mset,
    input  logic             wr_mclr,
    input  logic             wr_mode,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] mode_o
);
    typedef struct packed {
        logic [WIDTH-1:0] mask;
        logic [WIDTH-1:0] mode;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_mset) r_d.mask = r_q.mask | wdata;
        if (wr_mclr) r_d.mask = r_q.mask & ~wdata;
        if (wr_mode) r_d.mode = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mask <= '1;
            r_q.mode <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_o = r_q.mask;
    assign mode_o = r_q.mode;

    // R2: set bits land in the mask
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((r_q.mask & $past(wdata)) == $past(wdata)));
    // R3: cleared bits leave the mask, others keep their value
    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> (((r_q.mask & $past(wdata)) == '0) &&
                     ((r_q.mask & ~$past(wdata)) == ($past(r_q.mask) & ~$past(wdata)))));
endmodule

// File: rtl/irqc_cause.sv
module irqc_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             wr_cause,
    input  logic             wr_soft,
    input  logic             rd_cause,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] mode_i,
    output logic [WIDTH-1:0] cause_o
);
    typedef struct packed {
        logic [WIDTH-1:0] cause;
    } cause_t;

    cause_t c_d, c_q;
    logic [WIDTH-1:0] clr_hit;
    logic [WIDTH-1:0] set_hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            // mode 1: clear on read of the cause address; mode 0: write one to clear
            clr_hit[i] = mode_i[i] ? rd_cause : (wr_cause & wdata[i]);
            set_hit[i] = evt_i[i] | (wr_soft & wdata[i]);
        end
    end

    always_comb begin
        c_d = c_q;
        c_d.cause = (c_q.cause & ~clr_hit) | set_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cause_o = c_q.cause;

    // R4 and R8: an event always shows up at the next edge
    assert_evt_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((c_q.cause & $past(evt_i)) == $past(evt_i)));
    // R7: a read empties the clear-on-read bits that saw no new event
    assert_cor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause |=> ((c_q.cause & $past(mode_i) & ~$past(evt_i)) == '0));
    // R6: a cause write never touches clear-on-read bits
    assert_w1c_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((c_q.cause & $past(mode_i)) ==
                      (($past(c_q.cause) | $past(evt_i)) & $past(mode_i))));
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irqc_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  evt_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              irq_o
);
    irqc_strobe_t     stb;
    logic [WIDTH-1:0] mask_q, mode_q, cause_q, active;

    irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .stb_o    (stb)
    );

    irqc_ctrl_regs #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mset (stb.wr_mset),
        .wr_mclr (stb.wr_mclr),
        .wr_mode (stb.wr_mode),
        .wdata   (bus_wdata),
        .mask_o  (mask_q),
        .mode_o  (mode_q)
    );

    irqc_cause #(.WIDTH(WIDTH)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .wr_cause (stb.wr_cause),
        .wr_soft  (stb.wr_soft),
        .rd_cause (stb.rd_cause),
        .wdata    (bus_wdata),
        .mode_i   (mode_q),
        .cause_o  (cause_q)
    );

    always_comb begin
        active    = cause_q & ~mask_q;
        bus_rdata = '0;
        if (stb.rd_cause)  bus_rdata = cause_q;
        if (stb.rd_mode)   bus_rdata = mode_q;
        if (stb.rd_mview)  bus_rdata = mask_q;
        if (stb.rd_active) bus_rdata = active;
        irq_o = |active;
    end

    // R9: a fully masked group never interrupts
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);
    // R10: one read source at a time
    assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb.rd_cause, stb.rd_mode, stb.rd_mview, stb.rd_active}));
endmodule

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  evt = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit [W-1:0] m_cause, m_mask, m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cause_unit #(.WIDTH(W), .ADDR_W(3)) u_irq_cause_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cause <= '0;
            m_mask  <= '1;
            m_mode  <= '0;
        end else begin
            bit [W-1:0] c, m, md;
            c = m_cause; m = m_mask; md = m_mode;
            if (sel && wr) begin
                case (addr)
                    3'd0: c = c & ~(wdata & ~m_mode);
                    3'd1: m = m | wdata;
                    3'd2: m = m & ~wdata;
                    3'd3: md = wdata;
                    3'd4: c = c | wdata;
                    default: ;
                endcase
            end
            if (sel && !wr && addr == 3'd0) c = c & ~m_mode;
            c = c | evt;
            m_cause <= c; m_mask <= m; m_mode <= md;
        end
    end

    function automatic bit [W-1:0] model_rdata();
        if (!sel || wr) return '0;
        case (addr)
            3'd0: return m_cause;
            3'd3: return m_mode;
            3'd5: return m_mask;
            3'd6: return m_cause & ~m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq vs model", W'(irq), W'(|(m_cause & ~m_mask)));
            chk("R10 rdata vs model", rdata, model_rdata());
        end
    end

    task automatic cyc(logic s, logic w, logic [2:0] a, logic [W-1:0] d, logic [W-1:0] e);
        @(posedge clk);
        #1;
        sel = s; wr = w; addr = a; wdata = d; evt = e;
        @(negedge clk);
    endtask

    task automatic wr_reg(logic [2:0] a, logic [W-1:0] d);
        cyc(1'b1, 1'b1, a, d, '0);
    endtask

    task automatic rd_reg(logic [2:0] a, logic [W-1:0] exp, string tag, logic [W-1:0] e = '0);
        cyc(1'b1, 1'b0, a, '0, e);
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_reg(3'd5, 32'hFFFF_FFFF, "R1 mask after reset");
        chk("R1 irq after reset", W'(irq), '0);
        rd_reg(3'd0, 32'h0, "R1 cause after reset");
        rd_reg(3'd3, 32'h0, "R1 mode after reset");
        // R4 events captured while masked
        cyc(1'b0, 1'b0, 3'd0, '0, 32'h11);
        rd_reg(3'd0, 32'h11, "R4 events captured");
        chk("R9 masked cause gives no irq", W'(irq), '0);
        // R3 unmask bit 0
        wr_reg(3'd2, 32'h1);
        rd_reg(3'd5, 32'hFFFF_FFFE, "R3 mask clear");
        chk("R9 unmasked cause raises irq", W'(irq), 32'h1);
        rd_reg(3'd6, 32'h1, "R10 active view");
        // R2 re-mask
        wr_reg(3'd1, 32'h1);
        rd_reg(3'd5, 32'hFFFF_FFFF, "R2 mask set");
        chk("R9 irq drops after mask set", W'(irq), '0);
        // R6 write-one-to-clear
        wr_reg(3'd0, 32'h10);
        rd_reg(3'd0, 32'h1, "R6 w1c clears written bit only");
        // R5 and R7
        wr_reg(3'd3, 32'hF0);
        wr_reg(3'd4, 32'h30);
        rd_reg(3'd0, 32'h31, "R5 soft set, R7 read returns old value");
        rd_reg(3'd0, 32'h1, "R7 clear-on-read bits cleared");
        // R6: write ignored for clear-on-read bits
        wr_reg(3'd4, 32'h20);
        wr_reg(3'd0, 32'h21);
        rd_reg(3'd0, 32'h20, "R6 write ignored on cor bit");
        rd_reg(3'd0, 32'h0, "R7 cor bit cleared by read");
        // R8 event wins against clears
        cyc(1'b0, 1'b0, 3'd0, '0, 32'h4);
        cyc(1'b1, 1'b1, 3'd0, 32'h4, 32'h4);
        rd_reg(3'd0, 32'h4, "R8 event beats w1c");
        cyc(1'b0, 1'b0, 3'd0, '0, 32'h10);
        rd_reg(3'd0, 32'h14, "R8 read during event", 32'h10);
        rd_reg(3'd0, 32'h14, "R8 event beats cor");
        rd_reg(3'd0, 32'h4, "R7 cor bit cleared after event gone");
        // R10 views and unused addresses
        wr_reg(3'd3, 32'h14);
        wr_reg(3'd2, 32'h4);
        rd_reg(3'd6, 32'h4, "R10 active view");
        chk("R9 irq high", W'(irq), 32'h1);
        rd_reg(3'd6, 32'h4, "R10 active view does not clear");
        rd_reg(3'd0, 32'h4, "R7 read of cor bit");
        rd_reg(3'd5, 32'hFFFF_FFFB, "R10 mask view");
        chk("R9 irq low after clear", W'(irq), '0);
        rd_reg(3'd7, 32'h0, "R10 unused address");
        rd_reg(3'd4, 32'h0, "R10 write-only address");
        // random phase, compared every cycle
        for (int n = 0; n < 400; n++) begin
            cyc(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                3'($urandom_range(7, 0)), $urandom(),
                $urandom() & $urandom() & $urandom());
        end
        cyc(1'b0, 1'b0, 3'd0, '0, '0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule